// File: doc/BRIEF.md
# Banked Processor Mode Register File

This block is the general register file of a 32-bit processor with seven privilege modes. It offers sixteen architectural registers through two combinational read ports and one write port. It also holds the current status word and the live copy of the saved status word. Some privilege modes keep private copies of certain registers. The block stores those copies in shadow storage and swaps them in and out whenever the mode changes, so the rest of the core always sees the view of the current mode.

A mode change is requested with a one-cycle strobe and a 5-bit mode code. On the next clock edge the block does three things. It saves the outgoing mode's banked registers and saved status word. It loads the incoming mode's copies. It rewrites the mode field of the status word. Supervisor, IRQ, abort and undefined each bank the stack pointer (R13), the link register (R14) and a saved status word. User and system share one R13/R14 pair and have no saved status word. Fast-interrupt mode banks R8 through R14 and has its own saved status word. All the other modes share a single copy of R8 to R12.

Top module: `banked_regfile`

## Requirements
- R1: After reset, R13 reads 0x10000000 and every other register reads 0. The status word reads 0x000000D3: mode code 0x13 (supervisor) in bits [4:0], the IRQ mask in bit 7 and the FIQ mask in bit 6. The saved status word reads 0.
- R2: The mode codes in bits [4:0] are user 0x10, FIQ 0x11, IRQ 0x12, supervisor 0x13, abort 0x17, undefined 0x1B and system 0x1F. A request with any other code changes nothing.
- R3: A request that names the current mode changes nothing: no register, no saved status word and no status bit.
- R4: IRQ, supervisor, abort and undefined each keep their own R13/R14. On a switch, the outgoing mode's live R13/R14 are stored and the incoming mode's stored pair becomes visible after the same clock edge.
- R5: User and system modes share one R13/R14 pair, so a value written in one of them is seen in the other.
- R6: FIQ mode has private R8 to R14. Every other mode shares one copy of R8 to R12, and that copy is restored on leaving FIQ.
- R7: R0 to R7 and R15 are never banked. Their values are the same in every mode.
- R8: FIQ, IRQ, supervisor, abort and undefined each have a saved status slot. Leaving such a mode stores the live saved status word into its slot, and entering it loads the live word from that slot. Leaving user or system mode stores nothing.
- R9: A mode switch replaces only status bits [4:0]. A status write updates bits [31:5] and never the mode field.
- R10: A register write or a saved-status write in the same cycle as a mode switch goes into the outgoing mode's view.
- R11: Reads are combinational. A write becomes visible after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rd_a_addr_i | input | 4 | Read port A register index |
| rd_a_data_o | output | 32 | Read port A data |
| rd_b_addr_i | input | 4 | Read port B register index |
| rd_b_data_o | output | 32 | Read port B data |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write index |
| wr_data_i | input | 32 | Register write data |
| mode_req_i | input | 1 | Mode change request strobe |
| mode_code_i | input | 5 | Requested mode code |
| st_wr_en_i | input | 1 | Status write strobe (bits [31:5]) |
| st_wr_data_i | input | 32 | Status write data |
| sav_wr_en_i | input | 1 | Live saved status write strobe |
| sav_wr_data_i | input | 32 | Live saved status write data |
| status_o | output | 32 | Current status word |
| saved_status_o | output | 32 | Live saved status word |

## Verification
The assertions take for granted that inputs change only away from the rising edge, and that the strobes are sampled only on the edge where they are high. They make no claim about register contents when a strobe carries an unknown value. The stimulus drives every strobe for exactly one cycle, starting on a falling edge. It uses only the seven legal codes, except in the scenario that feeds deliberately illegal codes to confirm they are dropped. Each scenario starts from a fresh reset, so every expected value follows from the requirements alone.

// File: rtl/banked_rf_pkg.sv
package banked_rf_pkg;
  localparam int MODE_W = 5;

  typedef enum logic [MODE_W-1:0] {
    MD_USR = 5'h10,
    MD_FIQ = 5'h11,
    MD_IRQ = 5'h12,
    MD_SVC = 5'h13,
    MD_ABT = 5'h17,
    MD_UND = 5'h1B,
    MD_SYS = 5'h1F
  } mode_e;

  localparam int NUM_BANKS = 6;
  localparam int BANK_W    = $clog2(NUM_BANKS);
  typedef logic [BANK_W-1:0] bank_t;

  localparam bank_t BK_USR = 3'd0;
  localparam bank_t BK_FIQ = 3'd1;
  localparam bank_t BK_IRQ = 3'd2;
  localparam bank_t BK_SVC = 3'd3;
  localparam bank_t BK_ABT = 3'd4;
  localparam bank_t BK_UND = 3'd5;

  function automatic logic mode_ok(logic [MODE_W-1:0] m);
    case (m)
      MD_USR, MD_FIQ, MD_IRQ, MD_SVC, MD_ABT, MD_UND, MD_SYS: mode_ok = 1'b1;
      default:                                                mode_ok = 1'b0;
    endcase
  endfunction

  function automatic bank_t bank_of(logic [MODE_W-1:0] m);
    case (m)
      MD_FIQ:  bank_of = BK_FIQ;
      MD_IRQ:  bank_of = BK_IRQ;
      MD_SVC:  bank_of = BK_SVC;
      MD_ABT:  bank_of = BK_ABT;
      MD_UND:  bank_of = BK_UND;
      default: bank_of = BK_USR;
    endcase
  endfunction

  function automatic logic has_saved(logic [MODE_W-1:0] m);
    has_saved = mode_ok(m) && (m != MD_USR) && (m != MD_SYS);
  endfunction
endpackage

// File: rtl/brf_shadow_set.sv
module brf_shadow_set #(
  parameter int SLOTS = 2,
  parameter int WORDS = 3,
  parameter int W     = 32,
  localparam int SW   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [SW-1:0]            wslot_i,
  input  logic [WORDS-1:0]         wmask_i,
  input  logic [WORDS-1:0][W-1:0]  wdata_i,
  input  logic [SW-1:0]            rslot_i,
  output logic [WORDS-1:0][W-1:0]  rdata_o
);
  logic [SLOTS-1:0][WORDS-1:0][W-1:0] mem_q;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    for (genvar w = 0; w < WORDS; w++) begin : g_word
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          mem_q[s][w] <= '0;
        end else if (we_i && wmask_i[w] && (wslot_i == SW'(s))) begin
          mem_q[s][w] <= wdata_i[w];
        end
      end
    end
  end

  assign rdata_o = mem_q[rslot_i];
endmodule

// File: rtl/brf_mode_ctrl.sv
module brf_mode_ctrl
  import banked_rf_pkg::*;
#(
  parameter int          W          = 32,
  parameter logic [W-1:0] STATUS_RST = 32'h0000_00D3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [MODE_W-1:0] code_i,
  input  logic              st_wr_en_i,
  input  logic [W-1:0]      st_wr_data_i,
  output logic [W-1:0]      status_o,
  output logic [MODE_W-1:0] cur_mode_o,
  output logic              swap_o
);
  logic [W-1:0] status_q, status_d;

  assign cur_mode_o = status_q[MODE_W-1:0];
  assign swap_o     = req_i && mode_ok(code_i) && (code_i != cur_mode_o);

  always_comb begin
    status_d = status_q;
    if (st_wr_en_i) status_d[W-1:MODE_W] = st_wr_data_i[W-1:MODE_W];
    if (swap_o)     status_d[MODE_W-1:0] = code_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= STATUS_RST;
    else         status_q <= status_d;
  end

  assign status_o = status_q;
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import banked_rf_pkg::*;
#(
  parameter int          W          = 32,
  parameter logic [W-1:0] SP_RST     = 32'h1000_0000,
  parameter logic [W-1:0] PC_RST     = 32'h0000_0000,
  parameter logic [W-1:0] STATUS_RST = 32'h0000_00D3,
  localparam int NREG  = 16,
  localparam int IDX_W = $clog2(NREG),
  localparam int SP_IX = 13,
  localparam int LR_IX = 14,
  localparam int PC_IX = 15,
  localparam int HI_LO = 8,
  localparam int HI_N  = SP_IX - HI_LO
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_a_addr_i,
  output logic [W-1:0]      rd_a_data_o,
  input  logic [IDX_W-1:0]  rd_b_addr_i,
  output logic [W-1:0]      rd_b_data_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_addr_i,
  input  logic [W-1:0]      wr_data_i,
  input  logic              mode_req_i,
  input  logic [MODE_W-1:0] mode_code_i,
  input  logic              st_wr_en_i,
  input  logic [W-1:0]      st_wr_data_i,
  input  logic              sav_wr_en_i,
  input  logic [W-1:0]      sav_wr_data_i,
  output logic [W-1:0]      status_o,
  output logic [W-1:0]      saved_status_o
);
  logic [NREG-1:0][W-1:0] live_q, live_wv, live_d;
  logic [W-1:0]           sav_q, sav_wv, sav_d;
  logic [MODE_W-1:0]      cur_mode;
  logic                   swap;

  brf_mode_ctrl #(.W(W), .STATUS_RST(STATUS_RST)) u_mode (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (mode_req_i),
    .code_i      (mode_code_i),
    .st_wr_en_i  (st_wr_en_i),
    .st_wr_data_i(st_wr_data_i),
    .status_o    (status_o),
    .cur_mode_o  (cur_mode),
    .swap_o      (swap)
  );

  // outgoing-view values including this cycle's writes
  always_comb begin
    live_wv = live_q;
    if (wr_en_i) live_wv[wr_addr_i] = wr_data_i;
    sav_wv = sav_en_mux();
  end

  function automatic logic [W-1:0] sav_en_mux();
    return sav_wr_en_i ? sav_wr_data_i : sav_q;
  endfunction

  bank_t old_bank, new_bank;
  logic  same_pair, fiq_in, fiq_out, hi_swap;
  assign old_bank  = bank_of(cur_mode);
  assign new_bank  = bank_of(mode_code_i);
  assign same_pair = (old_bank == new_bank);
  assign fiq_in    = (mode_code_i == MD_FIQ);
  assign fiq_out   = (cur_mode == MD_FIQ);
  assign hi_swap   = swap && (fiq_in || fiq_out);

  // per-bank {saved status, R14, R13}
  logic [2:0][W-1:0] pair_wdata, pair_rdata;
  assign pair_wdata = {sav_wv, live_wv[LR_IX], live_wv[SP_IX]};

  brf_shadow_set #(.SLOTS(NUM_BANKS), .WORDS(3), .W(W)) u_pairs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (swap),
    .wslot_i(old_bank),
    .wmask_i({has_saved(cur_mode), 2'b11}),
    .wdata_i(pair_wdata),
    .rslot_i(new_bank),
    .rdata_o(pair_rdata)
  );

  // slot 0: shared R8..R12, slot 1: fast-interrupt R8..R12
  logic [HI_N-1:0][W-1:0] hi_wdata, hi_rdata;
  assign hi_wdata = live_wv[SP_IX-1:HI_LO];

  brf_shadow_set #(.SLOTS(2), .WORDS(HI_N), .W(W)) u_hi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (hi_swap),
    .wslot_i(fiq_out),
    .wmask_i({HI_N{1'b1}}),
    .wdata_i(hi_wdata),
    .rslot_i(fiq_in),
    .rdata_o(hi_rdata)
  );

  always_comb begin
    live_d = live_wv;
    sav_d  = sav_wv;
    if (swap) begin
      if (!same_pair) begin
        live_d[SP_IX] = pair_rdata[0];
        live_d[LR_IX] = pair_rdata[1];
      end
      if (hi_swap) live_d[SP_IX-1:HI_LO] = hi_rdata;
      if (has_saved(mode_code_i)) sav_d = pair_rdata[2];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q        <= '0;
      live_q[SP_IX] <= SP_RST;
      live_q[PC_IX] <= PC_RST;
      sav_q         <= '0;
    end else begin
      live_q <= live_d;
      sav_q  <= sav_d;
    end
  end

  assign rd_a_data_o    = live_q[rd_a_addr_i];
  assign rd_b_data_o    = live_q[rd_b_addr_i];
  assign saved_status_o = sav_q;
endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk
  import banked_rf_pkg::*;
#(
  parameter int W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mode_req_i,
  input logic [MODE_W-1:0] mode_code_i,
  input logic              st_wr_en_i,
  input logic [W-1:0]      status_o
);
  // R9
  mode_applied_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_req_i && mode_ok(mode_code_i) |=> status_o[MODE_W-1:0] == $past(mode_code_i));

  // R2
  bad_mode_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_req_i && !mode_ok(mode_code_i) && !st_wr_en_i |=> $stable(status_o));

  // R9
  upper_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !st_wr_en_i |=> $stable(status_o[W-1:MODE_W]));

  // R3
  idle_mode_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_req_i |=> $stable(status_o[MODE_W-1:0]));

  // R2
  mode_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_ok(status_o[MODE_W-1:0]));
endmodule

bind banked_regfile banked_regfile_chk #(.W(W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mode_req_i (mode_req_i),
  .mode_code_i(mode_code_i),
  .st_wr_en_i (st_wr_en_i),
  .status_o   (status_o)
);

// File: tb/banked_regfile_tb.sv
module banked_regfile_tb;
  localparam logic [31:0] SP0 = 32'h1000_0000;
  localparam logic [4:0] USR = 5'h10, FIQ = 5'h11, IRQ = 5'h12, SVC = 5'h13,
                         ABT = 5'h17, UND = 5'h1B, SYS = 5'h1F;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  rd_a_addr_i = '0, rd_b_addr_i = '0, wr_addr_i = '0;
  logic [31:0] rd_a_data_o, rd_b_data_o, wr_data_i = '0;
  logic        wr_en_i = 1'b0, mode_req_i = 1'b0, st_wr_en_i = 1'b0, sav_wr_en_i = 1'b0;
  logic [4:0]  mode_code_i = '0;
  logic [31:0] st_wr_data_i = '0, sav_wr_data_i = '0, status_o, saved_status_o;

  int checks = 0;
  int fails  = 0;

  always #5 clk_i = ~clk_i;

  banked_regfile u_dut (
    .clk_i, .rst_ni, .rd_a_addr_i, .rd_a_data_o, .rd_b_addr_i, .rd_b_data_o,
    .wr_en_i, .wr_addr_i, .wr_data_i, .mode_req_i, .mode_code_i,
    .st_wr_en_i, .st_wr_data_i, .sav_wr_en_i, .sav_wr_data_i,
    .status_o, .saved_status_o
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic chk_reg(string tag, int idx, logic [31:0] exp);
    rd_a_addr_i = 4'(idx);
    rd_b_addr_i = 4'(idx);
    #1;
    chk($sformatf("%s r%0d", tag, idx), rd_a_data_o, exp);
    chk($sformatf("%s r%0d portB", tag, idx), rd_b_data_o, exp);
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
    wr_en_i = 1'b0; mode_req_i = 1'b0; st_wr_en_i = 1'b0; sav_wr_en_i = 1'b0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    wr_en_i = 1'b0; mode_req_i = 1'b0; st_wr_en_i = 1'b0; sav_wr_en_i = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic wr(int idx, logic [31:0] d);
    wr_en_i = 1'b1; wr_addr_i = 4'(idx); wr_data_i = d;
    step();
  endtask

  task automatic mode(logic [4:0] m);
    mode_req_i = 1'b1; mode_code_i = m;
    step();
  endtask

  task automatic sav_wr(logic [31:0] d);
    sav_wr_en_i = 1'b1; sav_wr_data_i = d;
    step();
  endtask

  task automatic t_reset();
    do_reset();
    for (int i = 0; i < 16; i++) chk_reg("R1 reset", i, (i == 13) ? SP0 : 32'h0);
    chk("R1 status", status_o, 32'h0000_00D3);
    chk("R1 saved", saved_status_o, 32'h0);
  endtask

  task automatic t_unbanked();
    do_reset();
    wr_en_i = 1'b1; wr_addr_i = 4'd0; wr_data_i = 32'h11;
    chk_reg("R11 before edge", 0, 32'h0);
    step();
    chk_reg("R11 after edge", 0, 32'h11);
    wr(7, 32'h77);
    wr(15, 32'hF0);
    mode(FIQ);
    chk_reg("R7 fiq", 0, 32'h11);
    chk_reg("R7 fiq", 7, 32'h77);
    chk_reg("R7 fiq", 15, 32'hF0);
    mode(IRQ);
    chk_reg("R7 irq", 7, 32'h77);
    chk_reg("R7 irq", 15, 32'hF0);
  endtask

  task automatic t_exc_banks();
    do_reset();
    wr(13, 32'hA1); wr(14, 32'hA2); sav_wr(32'h53);
    mode(IRQ);
    chk_reg("R4 irq fresh", 13, 32'h0);
    chk_reg("R4 irq fresh", 14, 32'h0);
    chk("R8 irq fresh", saved_status_o, 32'h0);
    chk("R9 irq status", status_o, 32'h0000_00D2);
    wr(13, 32'hB1); wr(14, 32'hB2); sav_wr(32'h52);
    mode(ABT);
    chk_reg("R4 abt fresh", 13, 32'h0);
    wr(13, 32'hC1); sav_wr(32'h57);
    mode(UND);
    chk_reg("R4 und fresh", 13, 32'h0);
    wr(13, 32'hD1);
    mode(SVC);
    chk_reg("R4 svc back", 13, 32'hA1);
    chk_reg("R4 svc back", 14, 32'hA2);
    chk("R8 svc back", saved_status_o, 32'h53);
    mode(IRQ);
    chk_reg("R4 irq back", 13, 32'hB1);
    chk_reg("R4 irq back", 14, 32'hB2);
    chk("R8 irq back", saved_status_o, 32'h52);
    mode(ABT);
    chk_reg("R4 abt back", 13, 32'hC1);
    chk("R8 abt back", saved_status_o, 32'h57);
    mode(UND);
    chk_reg("R4 und back", 13, 32'hD1);
  endtask

  task automatic t_user_sys();
    do_reset();
    sav_wr(32'h53);
    mode(USR);
    chk_reg("R5 usr fresh", 13, 32'h0);
    chk("R9 usr status", status_o, 32'h0000_00D0);
    wr(13, 32'hE1); wr(14, 32'hE2);
    sav_wr(32'hBAD);
    mode(SYS);
    chk_reg("R5 sys shares", 13, 32'hE1);
    chk_reg("R5 sys shares", 14, 32'hE2);
    chk("R9 sys status", status_o, 32'h0000_00DF);
    wr(13, 32'hE3);
    mode(SVC);
    chk_reg("R5 svc own", 13, SP0);
    chk("R8 svc kept", saved_status_o, 32'h53);
    mode(USR);
    chk_reg("R5 usr sees sys", 13, 32'hE3);
    chk_reg("R5 usr sees sys", 14, 32'hE2);
    mode(IRQ);
    chk("R8 irq untouched", saved_status_o, 32'h0);
  endtask

  task automatic t_fiq();
    do_reset();
    for (int i = 8; i < 13; i++) wr(i, 32'h800 + 32'(i));
    mode(FIQ);
    chk("R9 fiq status", status_o, 32'h0000_00D1);
    for (int i = 8; i < 15; i++) chk_reg("R6 fiq fresh", i, 32'h0);
    for (int i = 8; i < 15; i++) wr(i, 32'hF00 + 32'(i));
    mode(IRQ);
    for (int i = 8; i < 13; i++) chk_reg("R6 shared restored", i, 32'h800 + 32'(i));
    chk_reg("R6 irq pair", 13, 32'h0);
    mode(FIQ);
    for (int i = 8; i < 15; i++) chk_reg("R6 fiq back", i, 32'hF00 + 32'(i));
    mode(SVC);
    for (int i = 8; i < 13; i++) chk_reg("R6 svc shared", i, 32'h800 + 32'(i));
    chk_reg("R6 svc sp", 13, SP0);
  endtask

  task automatic t_ignore();
    do_reset();
    wr(13, 32'h1234); sav_wr(32'h53);
    mode(5'h00);
    chk("R2 code 00 status", status_o, 32'h0000_00D3);
    chk_reg("R2 code 00", 13, 32'h1234);
    mode(5'h15);
    chk("R2 code 15 status", status_o, 32'h0000_00D3);
    chk_reg("R2 code 15", 13, 32'h1234);
    chk("R2 code 15 saved", saved_status_o, 32'h53);
    mode(SVC);
    chk("R3 same status", status_o, 32'h0000_00D3);
    chk_reg("R3 same", 13, 32'h1234);
    chk("R3 same saved", saved_status_o, 32'h53);
  endtask

  task automatic t_status();
    do_reset();
    st_wr_en_i = 1'b1; st_wr_data_i = 32'hA000_00FF;
    step();
    chk("R9 status write", status_o, 32'hA000_00F3);
    mode(ABT);
    chk("R9 switch keeps upper", status_o, 32'hA000_00F7);
    st_wr_en_i = 1'b1; st_wr_data_i = 32'h0;
    mode(IRQ);
    chk("R9 write with switch", status_o, 32'h0000_0012);
  endtask

  task automatic t_same_cycle();
    do_reset();
    wr_en_i = 1'b1; wr_addr_i = 4'd13; wr_data_i = 32'h1313;
    sav_wr_en_i = 1'b1; sav_wr_data_i = 32'h5555;
    mode(IRQ);
    chk_reg("R10 irq view", 13, 32'h0);
    chk("R10 irq saved", saved_status_o, 32'h0);
    mode(SVC);
    chk_reg("R10 old view kept", 13, 32'h1313);
    chk("R10 old saved kept", saved_status_o, 32'h5555);
    wr_en_i = 1'b1; wr_addr_i = 4'd9; wr_data_i = 32'h99;
    mode(FIQ);
    chk_reg("R10 fiq view", 9, 32'h0);
    mode(SVC);
    chk_reg("R10 shared r9", 9, 32'h99);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_unbanked();
    t_exc_banks();
    t_user_sys();
    t_fiq();
    t_ignore();
    t_status();
    t_same_cycle();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule